// File: doc/BRIEF.md
# Mailbox Transmit Frame

This block is the sending half of a word-oriented mailbox. A host reaches it through a small register bus. The address space is split into channel windows of 32 bytes each, followed by a frame-level register area. When the host writes a window's set register, the block emits a one-cycle set strobe that carries the window index and the written bits. The receiving side ORs those bits into its copy of that window's status. The receiver returns all of its status words on a flat input, and the host reads them back through the window's status register. Bits go away only when the receiver clears them.

Each window has a sticky transmit-done flag. The flag rises when the returned status of that window drops from nonzero to zero, which is the sign that the receiver has consumed the message. Each window also has an enable bit that admits its flag into a combined summary. The summary is a set of four 32-bit words with one bit per window. A single interrupt line is raised when the summary is nonzero and the frame-level combined-enable bit is set.

Before it may send, the host must raise an access request. Access-ready follows the request two cycles later, and set writes made while access-ready is low are dropped. The host bus is valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a read response is waiting and `rsp_ready` is low. A read response stays valid with stable data until it is taken. Writes produce no response.

Top module: `mbx_tx_frame`

## Requirements
- R1: After reset, `irq` and `set_stb` are 0, and the access-ready register (0xF8C), each window's done flag (window offset 0x10) and each window's enable (window offset 0x18) all read 0.
- R2: Window w sits at byte address w*0x20. A write to offset 0x0C, made while access-ready is 1, drives `set_stb` high for exactly one cycle, starting the cycle after acceptance, with `set_win`=w and `set_bits`=the write data. A read of offset 0x00 returns slice w of `remote_stat`.
- R3: A set write accepted while access-ready is 0 produces no strobe and leaves the receiver's status unchanged.
- R4: A window's done flag (bit 0 at offset 0x10) sets when that window's returned status goes from nonzero to all-zero. It does not set while the status stays nonzero, or while it stays zero.
- R5: Once set, a done flag stays set until a write with bit 0 = 1 reaches that window's clear register (offset 0x14). A write with bit 0 = 0 leaves it unchanged.
- R6: Combined word k (address 0xFA0 + 4*k, k = 0..3) has bit j set exactly when window 32*k+j has both its done flag and its enable bit (bit 0 of offset 0x18) set.
- R7: `irq` is 1 exactly when bit 2 of the frame interrupt-enable register (0xF98) is 1 and some combined bit is 1.
- R8: Writing 1 to the access-request register (0xF88) makes access-ready (0xF8C bit 0) read 1 from the second edge after the write is accepted. Writing 0 makes it read 0 from the second edge after that write.
- R9: The configuration register (0xF80) reads the window count in bits [6:0]. The identification register (0xFCC) reads the minor revision in bits [3:0] and the major revision in bits [7:4].
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0, and `rsp_valid` and `rsp_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the read response |
| rsp_data | output | 32 | Read data |
| set_stb | output | 1 | One-cycle set strobe toward the receiver |
| set_win | output | WIN_IW | Window index of the strobe |
| set_bits | output | 32 | Bits to OR into the receiver status |
| remote_stat | input | NWIN*32 | Returned status, window w in bits [32w+31:32w] |
| irq | output | 1 | Combined transmit-done interrupt |

## Verification
The embedded properties check the following on every cycle:
- a falling edge of a window's status to zero always leaves its done flag set;
- the flag persists until a qualifying clear;
- a set strobe never appears unless access-ready was high when the write was taken;
- access-ready only moves two edges after the request did;
- a stalled read response holds steady.

Other behaviours need the bench's scenarios: the exact address map, the OR accumulation seen through the receiver model, the filtering of the combined words by the enables, the frame-level gating of the interrupt, and the dropping of sends once the request is withdrawn.

// File: rtl/mbx_tx_pkg.sv
package mbx_tx_pkg;
  localparam int ADDR_W    = 12;
  localparam int DATA_W    = 32;
  localparam int MAX_WIN   = 124;
  localparam int CMB_WORDS = 4;
  localparam int CMB_BITS  = CMB_WORDS * DATA_W;

  // per-window offsets (low five address bits)
  localparam logic [4:0] WOFF_STAT = 5'h00;
  localparam logic [4:0] WOFF_SET  = 5'h0C;
  localparam logic [4:0] WOFF_DONE = 5'h10;
  localparam logic [4:0] WOFF_CLR  = 5'h14;
  localparam logic [4:0] WOFF_EN   = 5'h18;

  // frame-level addresses
  localparam logic [ADDR_W-1:0] FA_CFG    = 12'hF80;
  localparam logic [ADDR_W-1:0] FA_ACCREQ = 12'hF88;
  localparam logic [ADDR_W-1:0] FA_ACCRDY = 12'hF8C;
  localparam logic [ADDR_W-1:0] FA_FRMEN  = 12'hF98;
  localparam logic [ADDR_W-1:0] FA_CMB0   = 12'hFA0;
  localparam logic [ADDR_W-1:0] FA_ID     = 12'hFCC;

  localparam int FRMEN_W   = 3;
  localparam int FRMEN_CMB = 2;

  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/mbx_tx_window.sv
module mbx_tx_window
  import mbx_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t stat,
  input  logic  clr_wr,
  input  logic  en_wr,
  input  logic  wbit,
  output logic  done,
  output logic  en
);
  logic prev_nz;
  logic fall_zero;
  logic clr_hit;

  assign fall_zero = prev_nz && (stat == '0);
  assign clr_hit   = clr_wr && wbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_nz <= 1'b0;
      done    <= 1'b0;
      en      <= 1'b0;
    end else begin
      prev_nz <= (stat != '0);
      if (fall_zero)    done <= 1'b1;
      else if (clr_hit) done <= 1'b0;
      if (en_wr) en <= wbit;
    end
  end

  // R4
  fall_sets_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_nz && (stat == '0) |=> done);

  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !(clr_wr && wbit) |=> done);

  // R5
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && wbit && !(prev_nz && (stat == '0)) |=> !done);
endmodule

// File: rtl/mbx_tx_access.sv
module mbx_tx_access (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wbit,
  output logic req_q,
  output logic rdy
);
  logic stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      stage1 <= 1'b0;
      rdy    <= 1'b0;
    end else begin
      if (wr) req_q <= wbit;
      stage1 <= req_q;
      rdy    <= stage1;
    end
  end

  // R8
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(req_q, 2));

  // R8
  rdy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy) |-> !$past(req_q, 2));
endmodule

// File: rtl/mbx_tx_regif.sv
module mbx_tx_regif
  import mbx_tx_pkg::*;
#(
  parameter int NWIN       = 4,
  parameter int ARCH_MINOR = 1,
  parameter int ARCH_MAJOR = 2,
  localparam int WIN_IW    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  word_t                  req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output word_t                  rsp_data,
  input  logic [NWIN*DATA_W-1:0] win_stat,
  input  logic [NWIN-1:0]        win_done,
  input  logic [NWIN-1:0]        win_en,
  input  logic                   acc_req,
  input  logic                   acc_rdy,
  input  logic [FRMEN_W-1:0]     frm_en,
  input  logic [CMB_BITS-1:0]    cmb,
  output logic                   set_stb,
  output logic [WIN_IW-1:0]      set_win,
  output word_t                  set_bits,
  output logic [NWIN-1:0]        clr_wr,
  output logic [NWIN-1:0]        en_wr,
  output logic                   acc_wr,
  output logic                   frm_wr
);
  logic [6:0]        idx7;
  logic [WIN_IW-1:0] wsel;
  logic [4:0]        off;
  logic              win_hit;
  logic              wr_acc;
  logic              rd_acc;
  logic              set_now;
  word_t             rd;

  assign idx7      = req_addr[ADDR_W-1:5];
  assign wsel      = idx7[WIN_IW-1:0];
  assign off       = req_addr[4:0];
  assign win_hit   = idx7 < 7'(NWIN);
  assign req_ready = !rsp_valid || rsp_ready;
  assign wr_acc    = req_valid && req_ready && req_write;
  assign rd_acc    = req_valid && req_ready && !req_write;
  assign set_now   = wr_acc && win_hit && (off == WOFF_SET) && acc_rdy;
  assign acc_wr    = wr_acc && (req_addr == FA_ACCREQ);
  assign frm_wr    = wr_acc && (req_addr == FA_FRMEN);

  always_comb begin
    for (int i = 0; i < NWIN; i++) begin
      clr_wr[i] = wr_acc && win_hit && (off == WOFF_CLR) && (wsel == WIN_IW'(i));
      en_wr[i]  = wr_acc && win_hit && (off == WOFF_EN)  && (wsel == WIN_IW'(i));
    end
  end

  always_comb begin
    rd = '0;
    if (win_hit) begin
      case (off)
        WOFF_STAT: rd = win_stat[{wsel, 5'b0} +: DATA_W];
        WOFF_DONE: rd = {31'b0, win_done[wsel]};
        WOFF_EN:   rd = {31'b0, win_en[wsel]};
        default:   rd = '0;
      endcase
    end else begin
      case (req_addr)
        FA_CFG:    rd = {25'b0, 7'(NWIN)};
        FA_ACCREQ: rd = {31'b0, acc_req};
        FA_ACCRDY: rd = {31'b0, acc_rdy};
        FA_FRMEN:  rd = {29'b0, frm_en};
        FA_ID:     rd = {24'b0, 4'(ARCH_MAJOR), 4'(ARCH_MINOR)};
        default: begin
          if (req_addr[ADDR_W-1:4] == FA_CMB0[ADDR_W-1:4])
            rd = cmb[{req_addr[3:2], 5'b0} +: DATA_W];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      set_stb   <= 1'b0;
      set_win   <= '0;
      set_bits  <= '0;
    end else begin
      if (rd_acc) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      set_stb <= set_now;
      if (set_now) begin
        set_win  <= wsel;
        set_bits <= req_wdata;
      end
    end
  end

  // R3
  stb_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_stb |-> $past(acc_rdy));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
endmodule

// File: rtl/mbx_tx_frame.sv
module mbx_tx_frame
  import mbx_tx_pkg::*;
#(
  parameter int NWIN       = 4,
  parameter int ARCH_MINOR = 1,
  parameter int ARCH_MAJOR = 2,
  localparam int WIN_IW    = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   set_stb,
  output logic [WIN_IW-1:0]      set_win,
  output logic [DATA_W-1:0]      set_bits,
  input  logic [NWIN*DATA_W-1:0] remote_stat,
  output logic                   irq
);
  logic [NWIN-1:0]     win_done;
  logic [NWIN-1:0]     win_en;
  logic [NWIN-1:0]     clr_wr;
  logic [NWIN-1:0]     en_wr;
  logic                acc_wr;
  logic                frm_wr;
  logic                acc_req;
  logic                acc_rdy;
  logic [FRMEN_W-1:0]  frm_en;
  logic [CMB_BITS-1:0] cmb;

  assign cmb = {{(CMB_BITS-NWIN){1'b0}}, win_done & win_en};
  assign irq = frm_en[FRMEN_CMB] && (cmb != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      frm_en <= '0;
    else if (frm_wr) frm_en <= req_wdata[FRMEN_W-1:0];
  end

  mbx_tx_regif #(.NWIN(NWIN), .ARCH_MINOR(ARCH_MINOR), .ARCH_MAJOR(ARCH_MAJOR)) u_regif (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .win_stat(remote_stat), .win_done(win_done), .win_en(win_en),
    .acc_req(acc_req), .acc_rdy(acc_rdy), .frm_en(frm_en), .cmb(cmb),
    .set_stb(set_stb), .set_win(set_win), .set_bits(set_bits),
    .clr_wr(clr_wr), .en_wr(en_wr), .acc_wr(acc_wr), .frm_wr(frm_wr)
  );

  mbx_tx_access u_access (
    .clk(clk), .rst_n(rst_n), .wr(acc_wr), .wbit(req_wdata[0]),
    .req_q(acc_req), .rdy(acc_rdy)
  );

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    mbx_tx_window u_win (
      .clk(clk), .rst_n(rst_n),
      .stat(remote_stat[g*DATA_W +: DATA_W]),
      .clr_wr(clr_wr[g]), .en_wr(en_wr[g]), .wbit(req_wdata[0]),
      .done(win_done[g]), .en(win_en[g])
    );
  end
endmodule

// File: tb/tb_mbx_tx_frame.sv
`timescale 1ns/1ps
module tb_mbx_tx_frame;
  localparam int NW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        set_stb;
  logic [1:0]  set_win;
  logic [31:0] set_bits;
  logic [NW*32-1:0] remote_stat;
  logic        irq;

  logic [31:0] rx [NW];
  logic        clr_stb = 1'b0;
  logic [1:0]  clr_win = '0;
  logic [31:0] clr_mask = '0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic        last_stb;
  logic [1:0]  last_win;
  logic [31:0] last_bits;
  logic [31:0] rv;

  always #4 clk = ~clk;

  mbx_tx_frame #(.NWIN(NW), .ARCH_MINOR(1), .ARCH_MAJOR(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .set_stb(set_stb), .set_win(set_win), .set_bits(set_bits),
    .remote_stat(remote_stat), .irq(irq)
  );

  // receiver model: ORs set strobes in, clears on request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) rx[i] <= '0;
    end else begin
      if (set_stb) rx[set_win] <= rx[set_win] | set_bits;
      if (clr_stb) rx[clr_win] <= rx[clr_win] & ~clr_mask;
    end
  end
  assign remote_stat = {rx[3], rx[2], rx[1], rx[0]};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    last_stb = set_stb; last_win = set_win; last_bits = set_bits;
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    d = rsp_data;
    req_valid = 1'b0;
  endtask

  task automatic rx_clear(input logic [1:0] w, input logic [31:0] m);
    @(negedge clk);
    clr_stb = 1'b1; clr_win = w; clr_mask = m;
    @(negedge clk);
    clr_stb = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  // {window, set value, expected readback}
  localparam logic [71:0] VEC [6] = '{
    {8'd0, 32'h0000_0001, 32'h0000_0001},
    {8'd0, 32'h8000_0000, 32'h8000_0001},
    {8'd1, 32'hA5A5_0000, 32'hA5A5_0000},
    {8'd3, 32'h0000_FFFF, 32'h0000_FFFF},
    {8'd1, 32'h0000_5A5A, 32'hA5A5_5A5A},
    {8'd2, 32'h0000_0000, 32'h0000_0000}
  };

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    if (!finished) begin
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    chk("R1 set_stb", {31'b0, set_stb}, 32'd0);
    rd(12'hF8C, rv); chk("R1 access ready", rv, 32'd0);
    rd(12'h010, rv); chk("R1 done w0", rv, 32'd0);
    rd(12'h078, rv); chk("R1 enable w3", rv, 32'd0);
    // R9 identification
    rd(12'hF80, rv); chk("R9 window count", rv, 32'd4);
    rd(12'hFCC, rv); chk("R9 revision", rv, 32'h21);
    // R3 send before access granted
    wr(12'h00C, 32'h0000_00FF);
    chk("R3 no strobe", {31'b0, last_stb}, 32'd0);
    rd(12'h000, rv); chk("R3 status untouched", rv, 32'd0);
    // R8 request, ready two edges later
    wr(12'hF88, 32'd1);
    rd(12'hF8C, rv); chk("R8 ready not early", rv, 32'd0);
    rd(12'hF8C, rv); chk("R8 ready up", rv, 32'd1);
    // R2 table of sends and readbacks
    for (int i = 0; i < 6; i++) begin
      wr({VEC[i][65:64], 5'h0C}, VEC[i][63:32]);
      chk("R2 strobe", {31'b0, last_stb}, 32'd1);
      chk("R2 strobe window", {30'b0, last_win}, {30'b0, VEC[i][65:64]});
      chk("R2 strobe bits", last_bits, VEC[i][63:32]);
      chk("R2 one-cycle strobe", {31'b0, set_stb}, 32'd0);
      rd({VEC[i][65:64], 5'h00}, rv);
      chk("R2 status readback", rv, VEC[i][31:0]);
    end
    // R4 partial clear does not flag, full clear does
    wr(12'h018, 32'd1);
    wr(12'hF98, 32'd4);
    rx_clear(2'd0, 32'h0000_0001);
    rd(12'h010, rv); chk("R4 nonzero keeps flag low", rv, 32'd0);
    chk("R7 irq low", {31'b0, irq}, 32'd0);
    rx_clear(2'd0, 32'h8000_0000);
    rd(12'h010, rv); chk("R4 flag on fall to zero", rv, 32'd1);
    rd(12'h050, rv); chk("R4 idle zero window", rv, 32'd0);
    chk("R7 irq high", {31'b0, irq}, 32'd1);
    rd(12'hFA0, rv); chk("R6 combined w0", rv, 32'h1);
    // R6 flag without enable is filtered
    rx_clear(2'd3, 32'hFFFF_FFFF);
    rd(12'h070, rv); chk("R4 flag w3", rv, 32'd1);
    rd(12'hFA0, rv); chk("R6 disabled w3 hidden", rv, 32'h1);
    wr(12'h078, 32'd1);
    rd(12'hFA0, rv); chk("R6 both windows", rv, 32'h9);
    rd(12'hFA4, rv); chk("R6 upper word", rv, 32'h0);
    // R7 frame gate
    wr(12'hF98, 32'd3);
    chk("R7 gated off", {31'b0, irq}, 32'd0);
    wr(12'hF98, 32'd4);
    chk("R7 gated on", {31'b0, irq}, 32'd1);
    // R5 clear semantics
    wr(12'h014, 32'd0);
    rd(12'h010, rv); chk("R5 bit0 zero ignored", rv, 32'd1);
    wr(12'h014, 32'd1);
    rd(12'h010, rv); chk("R5 cleared", rv, 32'd0);
    rd(12'hFA0, rv); chk("R5 combined after clear", rv, 32'h8);
    wr(12'h074, 32'd1);
    chk("R5 irq drops", {31'b0, irq}, 32'd0);
    // R10 stalled response
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 12'hF80;
    @(negedge clk);
    req_addr = 12'hFCC;
    chk("R10 valid", {31'b0, rsp_valid}, 32'd1);
    chk("R10 ready low", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk("R10 data held", rsp_data, 32'd4);
    chk("R10 still valid", {31'b0, rsp_valid}, 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second read", rsp_data, 32'h21);
    // R8 withdrawal, then R3 send dropped
    wr(12'hF88, 32'd0);
    rd(12'hF8C, rv); chk("R8 ready still up", rv, 32'd1);
    rd(12'hF8C, rv); chk("R8 ready down", rv, 32'd0);
    wr(12'h02C, 32'hFFFF_FFFF);
    chk("R3 dropped after withdraw", {31'b0, last_stb}, 32'd0);
    rd(12'h020, rv); chk("R3 w1 unchanged", rv, 32'hA5A5_5A5A);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule